// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Unit

This block sits beside a processor's local data bus and turns breakpoint conditions into a two-stage trigger. Software loads a single 32-bit, write-only trigger definition word. The word holds two 14-bit level descriptors and a 2-bit response selector. Each level can require any combination of three conditions. The first is a data match on a chosen byte lane, word half or full longword. The second is a hit from an external address comparator. The third is a hit from an external program-counter comparator. The data and PC conditions can each be inverted.

The first level must fire and be latched before the second level is armed. When the programmed sequence completes, the unit always emits a one-cycle trace event. Depending on the response selector, it also emits a one-cycle halt request or a one-cycle debug interrupt. The unit then holds its completed status until the definition word is written again. A write re-arms the sequence and clears the trigger status.

Top module: `brk_trig_unit`

## Requirements
- R1: After reset the definition word is all zeros, `trig_state` is 000, and `halt_req`, `dbg_irq` and `trace_evt` are low. No condition fires until a write arrives.
- R2: A write takes effect at the next clock edge. After that edge `trig_state` is 001 if the level-1 enable (bit 13) of the written word is set, and 000 otherwise. This holds whatever the previous status was, including a completed trigger.
- R3: The unit uses a set of seven lane enables (bits 12:6 for level 1, bits 28:22 for level 2, index 0 at the lowest bit). Only the one lane that the transfer drives can match, and its bytes are compared in place against that level's reference value.
  - Size 00 is a byte: offsets 0, 1, 2 and 3 select index 0 (data bits 31:24), index 1 (23:16), index 2 (15:8) and index 3 (7:0).
  - Size 01 is a word: offset bit 1 clear selects index 4 (bits 31:16), and set selects index 5 (bits 15:0).
  - Size 10 is a longword and selects index 6.
  - Size 11 matches nothing.
- R4: A level with its global enable set but with no condition programmed never fires. No condition programmed means all lane enables, the 3-bit address-enable field and the PC-enable bit are zero.
- R5: With the data-invert bit set (bit 5 for level 1, bit 21 for level 2), the data condition holds when the selected, enabled lane differs from the reference value, and fails when it equals it.
- R6: A nonzero address-enable field (bits 4:2 / 20:18) makes the level require that level's address-hit input during a valid bus transfer.
- R7: The PC-enable bit (bit 1 / 17) makes the level require that level's PC-hit input, with or without a bus transfer. The PC-invert bit (bit 0 / 16) reverses the sense of that input.
- R8: All conditions programmed for a level must hold in the same cycle for that level to fire.
- R9: With both levels enabled, the level-2 condition is ignored until level 1 has fired.
  - A level-1 hit moves `trig_state` to 010 and raises no response, even when level 2 holds in the same cycle.
  - A later level-2 hit moves `trig_state` to 011 and raises the response.
- R10: When the level-2 enable (bit 29) is clear, a level-1 hit completes the trigger directly (`trig_state` 011), whatever the level-2 lanes hold.
- R11: On completion, `trace_evt` is high for exactly the cycle after the completing hit. The response field (bits 31:30) adds more in that same cycle:
  - 01 adds a one-cycle `halt_req`.
  - 10 adds a one-cycle `dbg_irq`.
  - 00 and 11 add nothing.
- R12: Once the status is 011, further hits on either level produce no pulse and the status stays 011 until the next write.
- R13: With the level-1 enable clear, the unit stays at status 000 and never fires, even if level 2 is enabled and its conditions hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the trigger definition word |
| cfg_wr_data | input | 32 | Value written to the trigger definition word |
| bus_valid | input | 1 | A data bus transfer is present this cycle |
| bus_byte_off | input | 2 | Low two address bits of the transfer |
| bus_size | input | 2 | Transfer size: 00 byte, 01 word, 10 longword |
| bus_data | input | 32 | Transfer data |
| l1_data_ref | input | 32 | Level-1 data reference value |
| l2_data_ref | input | 32 | Level-2 data reference value |
| l1_addr_hit | input | 1 | Level-1 address comparator hit |
| l2_addr_hit | input | 1 | Level-2 address comparator hit |
| l1_pc_hit | input | 1 | Level-1 PC comparator hit |
| l2_pc_hit | input | 1 | Level-2 PC comparator hit |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt |
| trace_evt | output | 1 | One-cycle trace event on every completion |
| trig_state | output | 3 | Trigger status: 000 idle, 001 wait L1, 010 wait L2, 011 complete |

## Verification
A write lands on the first rising edge after it is driven, so the new status is sampled half a cycle later. A condition presented in one cycle is latched at the next edge, so status changes and response pulses are due exactly one edge after the stimulus. The bench drives every stimulus on a falling edge, holds it through one rising edge and samples at the following falling edge. A second sample one cycle later confirms that each pulse has dropped. The lane sweep covers every transfer placement against every single-lane enable, in both matching and mismatching data, and compares against a placement-to-lane function written separately in the bench.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int REG_W       = 32;
  localparam int DATA_W      = 32;
  localparam int BYTES       = DATA_W / 8;
  localparam int LANES       = 7;
  localparam int AE_W        = 3;
  localparam int HALF_W      = 16;
  localparam int LVL_W       = LANES + AE_W + 4;
  localparam int NUM_LEVELS  = 2;
  localparam int RESP_LSB    = 30;
  localparam int L1_EBL_BIT  = LVL_W - 1;
  localparam int L2_EBL_BIT  = HALF_W + LVL_W - 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } bus_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_WAIT1 = 3'b001,
    ST_WAIT2 = 3'b010,
    ST_DONE  = 3'b011
  } trig_state_e;

  typedef enum logic [1:0] {
    RSP_TRACE = 2'b00,
    RSP_HALT  = 2'b01,
    RSP_IRQ   = 2'b10,
    RSP_RSVD  = 2'b11
  } resp_e;

  // one level descriptor, MSB first: enable, lanes, data invert,
  // address enable, pc enable, pc invert
  typedef struct packed {
    logic             ebl;
    logic [LANES-1:0] lanes;
    logic             dinv;
    logic [AE_W-1:0]  aen;
    logic             pcen;
    logic             pcinv;
  } level_cfg_t;

  // one-hot lane that a transfer of this size and placement drives
  function automatic logic [LANES-1:0] lane_of(input logic [1:0] size,
                                               input logic [1:0] off);
    logic [LANES-1:0] sel;
    sel = '0;
    case (size)
      SZ_BYTE: sel[off] = 1'b1;
      SZ_WORD: sel[off[1] ? 5 : 4] = 1'b1;
      SZ_LONG: sel[6] = 1'b1;
      default: sel = '0;
    endcase
    return sel;
  endfunction

  // byte mask (bit 3 = data[31:24]) covered by a set of lanes
  function automatic logic [BYTES-1:0] bytes_of(input logic [LANES-1:0] sel);
    logic [BYTES-1:0] m;
    m[3] = sel[0] | sel[4] | sel[6];
    m[2] = sel[1] | sel[4] | sel[6];
    m[1] = sel[2] | sel[5] | sel[6];
    m[0] = sel[3] | sel[5] | sel[6];
    return m;
  endfunction

  function automatic logic masked_equal(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [BYTES-1:0]  m);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < BYTES; i++) begin
      if (m[i] && (a[8*i +: 8] != b[8*i +: 8])) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/brk_tdef_reg.sv
module brk_tdef_reg
  import brk_pkg::*;
#(
  parameter logic [REG_W-1:0] ZERO_MASK = 32'h0000_C000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] tdef_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tdef_q <= '0;
    else if (wr_en) tdef_q <= wr_data & ~ZERO_MASK;
  end

  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tdef_q & ZERO_MASK) == '0);

endmodule

// File: rtl/brk_level_match.sv
module brk_level_match
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  level_cfg_t        cfg,
  input  logic              bus_valid,
  input  logic [1:0]        bus_off,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] data_ref,
  input  logic              addr_hit,
  input  logic              pc_hit,
  output logic              lvl_hit
);

  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] lane_on;
  logic [BYTES-1:0] byte_mask;
  logic             data_used, addr_used, pc_used, any_used;
  logic             data_eq, data_ok, addr_ok, pc_ok;

  always_comb begin
    lane_sel  = lane_of(bus_size, bus_off);
    lane_on   = lane_sel & cfg.lanes;
    byte_mask = bytes_of(lane_on);
    data_eq   = masked_equal(bus_data, data_ref, byte_mask);

    data_used = |cfg.lanes;
    addr_used = |cfg.aen;
    pc_used   = cfg.pcen;
    any_used  = data_used | addr_used | pc_used;

    data_ok   = bus_valid & (|lane_on) & (data_eq ^ cfg.dinv);
    addr_ok   = bus_valid & addr_hit;
    pc_ok     = pc_hit ^ cfg.pcinv;

    lvl_hit   = cfg.ebl & any_used
              & (~data_used | data_ok)
              & (~addr_used | addr_ok)
              & (~pc_used   | pc_ok);
  end

  a_r6_addr_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cfg.aen) && !bus_valid) |-> !lvl_hit);

  a_r13_disabled_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.ebl |-> !lvl_hit);

  a_r3_reserved_size_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cfg.lanes) && bus_size == SZ_RSVD) |-> !lvl_hit);

endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        arm_next,
  input  logic        l2_en,
  input  logic [1:0]  resp,
  input  logic        l1_hit,
  input  logic        l2_hit,
  output trig_state_e state,
  output logic        halt_req,
  output logic        dbg_irq,
  output logic        trace_evt
);

  trig_state_e state_d;
  logic        fire;

  always_comb begin
    state_d = state;
    fire    = 1'b0;
    if (wr_en) begin
      state_d = arm_next ? ST_WAIT1 : ST_IDLE;
    end else begin
      case (state)
        ST_WAIT1: if (l1_hit) begin
          if (l2_en) state_d = ST_WAIT2;
          else begin
            state_d = ST_DONE;
            fire    = 1'b1;
          end
        end
        ST_WAIT2: if (l2_hit) begin
          state_d = ST_DONE;
          fire    = 1'b1;
        end
        default: state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      halt_req  <= 1'b0;
      dbg_irq   <= 1'b0;
      trace_evt <= 1'b0;
    end else begin
      state     <= state_d;
      trace_evt <= fire;
      halt_req  <= fire && (resp == RSP_HALT);
      dbg_irq   <= fire && (resp == RSP_IRQ);
    end
  end

  a_r11_halt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

  a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> !dbg_irq);

  a_r11_response_traced: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |-> trace_evt);

  a_r11_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq));

  a_r12_trace_means_done: assert property (@(posedge clk) disable iff (!rst_n)
    trace_evt |-> state == ST_DONE);

  a_r12_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !wr_en) |=> (state == ST_DONE && !trace_evt));

  a_r2_write_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state == ST_IDLE || state == ST_WAIT1));

  a_r9_no_skip_level2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT1 && l2_en && !wr_en) |=> state != ST_DONE);

  a_r13_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !wr_en) |=> (state == ST_IDLE && !trace_evt));

endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              bus_valid,
  input  logic [1:0]        bus_byte_off,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] l1_data_ref,
  input  logic [DATA_W-1:0] l2_data_ref,
  input  logic              l1_addr_hit,
  input  logic              l2_addr_hit,
  input  logic              l1_pc_hit,
  input  logic              l2_pc_hit,
  output logic              halt_req,
  output logic              dbg_irq,
  output logic              trace_evt,
  output logic [2:0]        trig_state
);

  logic [REG_W-1:0]      tdef_q;
  level_cfg_t            lvl_cfg  [NUM_LEVELS];
  logic [DATA_W-1:0]     lvl_ref  [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] lvl_ahit;
  logic [NUM_LEVELS-1:0] lvl_phit;
  logic [NUM_LEVELS-1:0] lvl_hit;
  trig_state_e           state;
  logic [1:0]            spare_bits;

  brk_tdef_reg u_tdef (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .tdef_q  (tdef_q)
  );

  assign lvl_ref[0] = l1_data_ref;
  assign lvl_ref[1] = l2_data_ref;
  assign lvl_ahit   = {l2_addr_hit, l1_addr_hit};
  assign lvl_phit   = {l2_pc_hit, l1_pc_hit};
  assign spare_bits = tdef_q[HALF_W-1 -: 2];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    assign lvl_cfg[g] = level_cfg_t'(tdef_q[g*HALF_W +: LVL_W]);

    brk_level_match u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (lvl_cfg[g]),
      .bus_valid (bus_valid),
      .bus_off   (bus_byte_off),
      .bus_size  (bus_size),
      .bus_data  (bus_data),
      .data_ref  (lvl_ref[g]),
      .addr_hit  (lvl_ahit[g]),
      .pc_hit    (lvl_phit[g]),
      .lvl_hit   (lvl_hit[g])
    );
  end

  brk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .arm_next  (cfg_wr_data[L1_EBL_BIT]),
    .l2_en     (lvl_cfg[1].ebl),
    .resp      (tdef_q[RESP_LSB +: 2]),
    .l1_hit    (lvl_hit[0]),
    .l2_hit    (lvl_hit[1]),
    .state     (state),
    .halt_req  (halt_req),
    .dbg_irq   (dbg_irq),
    .trace_evt (trace_evt)
  );

  assign trig_state = state;

  a_r1_spare_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
    spare_bits == 2'b00);

  a_r10_direct_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT1 && !lvl_cfg[1].ebl && lvl_hit[0] && !cfg_wr_en)
      |=> (trace_evt && state == ST_DONE));

endmodule

// File: tb/brk_trig_unit_tb_top.sv
module brk_trig_unit_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic        bus_valid;
  logic [1:0]  bus_byte_off;
  logic [1:0]  bus_size;
  logic [31:0] bus_data;
  logic [31:0] l1_data_ref;
  logic [31:0] l2_data_ref;
  logic        l1_addr_hit, l2_addr_hit, l1_pc_hit, l2_pc_hit;
  logic        halt_req, dbg_irq, trace_evt;
  logic [2:0]  trig_state;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  brk_trig_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_data  (cfg_wr_data),
    .bus_valid    (bus_valid),
    .bus_byte_off (bus_byte_off),
    .bus_size     (bus_size),
    .bus_data     (bus_data),
    .l1_data_ref  (l1_data_ref),
    .l2_data_ref  (l2_data_ref),
    .l1_addr_hit  (l1_addr_hit),
    .l2_addr_hit  (l2_addr_hit),
    .l1_pc_hit    (l1_pc_hit),
    .l2_pc_hit    (l2_pc_hit),
    .halt_req     (halt_req),
    .dbg_irq      (dbg_irq),
    .trace_evt    (trace_evt),
    .trig_state   (trig_state)
  );

  function automatic logic [13:0] lv(input bit ebl, input logic [6:0] lanes,
                                     input bit di, input logic [2:0] ae,
                                     input bit pe, input bit pi);
    return {ebl, lanes, di, ae, pe, pi};
  endfunction

  function automatic logic [31:0] tdr(input logic [1:0] rsp,
                                      input logic [13:0] l2,
                                      input logic [13:0] l1);
    return {rsp, l2, 2'b00, l1};
  endfunction

  // lane index a transfer drives: bytes by offset, words 4/5, long 6
  function automatic int exp_lane(input int sz, input int off);
    if (sz == 0) return off;
    if (sz == 1) return (off >= 2) ? 5 : 4;
    if (sz == 2) return 6;
    return -1;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
    bus_valid   = 1'b0;
    bus_byte_off = '0;
    bus_size    = '0;
    bus_data    = '0;
    l1_addr_hit = 1'b0;
    l2_addr_hit = 1'b0;
    l1_pc_hit   = 1'b0;
    l2_pc_hit   = 1'b0;
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    idle_inputs();
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    idle_inputs();
  endtask

  // drive one cycle of stimulus; return at the following falling edge
  task automatic apply(input bit v, input int off, input int sz,
                       input logic [31:0] d, input bit a1, input bit a2,
                       input bit p1, input bit p2);
    bus_valid    = v;
    bus_byte_off = 2'(off);
    bus_size     = 2'(sz);
    bus_data     = d;
    l1_addr_hit  = a1;
    l2_addr_hit  = a2;
    l1_pc_hit    = p1;
    l2_pc_hit    = p2;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic expect_out(input string req, input bit h, input bit i,
                            input bit t, input logic [2:0] st);
    chk(req, "halt_req",   32'(halt_req),   32'(h));
    chk(req, "dbg_irq",    32'(dbg_irq),    32'(i));
    chk(req, "trace_evt",  32'(trace_evt),  32'(t));
    chk(req, "trig_state", 32'(trig_state), 32'(st));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc1_only;
    idle_inputs();
    l1_data_ref = 32'hA1B2_C3D4;
    l2_data_ref = 32'h5E6F_7081;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, nothing fires before a write
    expect_out("R1", 0, 0, 0, 3'b000);
    apply(1, 0, 2, l1_data_ref, 1, 1, 1, 1);
    expect_out("R1", 0, 0, 0, 3'b000);

    // R3: every placement against every single-lane enable, halt response
    for (int t = 0; t < 7; t++) begin
      int sz;
      int off;
      sz  = (t < 4) ? 0 : (t < 6) ? 1 : 2;
      off = (t < 4) ? t : (t == 4) ? 0 : (t == 5) ? 2 : 0;
      for (int e = 0; e < 7; e++) begin
        bit hit;
        hit = (exp_lane(sz, off) == e);
        write_cfg(tdr(2'b01, 14'h0, lv(1, 7'(1 << e), 0, 0, 0, 0)));
        chk("R2", "state after write", 32'(trig_state), 32'd1);
        apply(1, off, sz, l1_data_ref, 0, 0, 0, 0);
        expect_out("R3", hit, 0, hit, hit ? 3'b011 : 3'b001);
      end
      // mismatching data on the driven lane never matches
      write_cfg(tdr(2'b01, 14'h0, lv(1, 7'(1 << exp_lane(sz, off)), 0, 0, 0, 0)));
      apply(1, off, sz, ~l1_data_ref, 0, 0, 0, 0);
      expect_out("R3", 0, 0, 0, 3'b001);
    end

    // R3: reserved size matches nothing, even with all lanes on
    write_cfg(tdr(2'b01, 14'h0, lv(1, 7'h7F, 0, 0, 0, 0)));
    apply(1, 0, 3, l1_data_ref, 0, 0, 0, 0);
    expect_out("R3", 0, 0, 0, 3'b001);

    // R3: only the driven byte is compared
    write_cfg(tdr(2'b01, 14'h0, lv(1, 7'b0001000, 0, 0, 0, 0)));
    apply(1, 3, 0, {~l1_data_ref[31:8], l1_data_ref[7:0]}, 0, 0, 0, 0);
    expect_out("R3", 1, 0, 1, 3'b011);

    // R4: enabled level without any condition never fires
    write_cfg(tdr(2'b01, 14'h0, lv(1, 0, 0, 0, 0, 0)));
    apply(1, 0, 2, l1_data_ref, 1, 1, 1, 1);
    expect_out("R4", 0, 0, 0, 3'b001);

    // R5: data invert
    write_cfg(tdr(2'b01, 14'h0, lv(1, 7'b0000001, 1, 0, 0, 0)));
    apply(1, 0, 0, l1_data_ref, 0, 0, 0, 0);
    expect_out("R5", 0, 0, 0, 3'b001);
    apply(1, 0, 0, ~l1_data_ref, 0, 0, 0, 0);
    expect_out("R5", 1, 0, 1, 3'b011);

    // R6: address condition needs a valid transfer
    write_cfg(tdr(2'b01, 14'h0, lv(1, 0, 0, 3'b001, 0, 0)));
    apply(0, 0, 2, 0, 1, 0, 0, 0);
    expect_out("R6", 0, 0, 0, 3'b001);
    apply(1, 0, 2, 0, 0, 1, 0, 0);
    expect_out("R6", 0, 0, 0, 3'b001);
    apply(1, 0, 2, 0, 1, 0, 0, 0);
    expect_out("R6", 1, 0, 1, 3'b011);

    // R7: pc condition and its invert
    write_cfg(tdr(2'b01, 14'h0, lv(1, 0, 0, 0, 1, 0)));
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R7", 1, 0, 1, 3'b011);
    write_cfg(tdr(2'b01, 14'h0, lv(1, 0, 0, 0, 1, 1)));
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R7", 0, 0, 0, 3'b001);
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    expect_out("R7", 1, 0, 1, 3'b011);

    // R8: data and address both required
    write_cfg(tdr(2'b01, 14'h0, lv(1, 7'b1000000, 0, 3'b010, 0, 0)));
    apply(1, 0, 2, l1_data_ref, 0, 0, 0, 0);
    expect_out("R8", 0, 0, 0, 3'b001);
    apply(1, 0, 2, ~l1_data_ref, 1, 0, 0, 0);
    expect_out("R8", 0, 0, 0, 3'b001);
    apply(1, 0, 2, l1_data_ref, 1, 0, 0, 0);
    expect_out("R8", 1, 0, 1, 3'b011);

    // R9: two-level sequence
    write_cfg(tdr(2'b01, lv(1, 0, 0, 0, 1, 0), lv(1, 0, 0, 0, 1, 0)));
    apply(0, 0, 0, 0, 0, 0, 0, 1);
    expect_out("R9", 0, 0, 0, 3'b001);
    apply(0, 0, 0, 0, 0, 0, 1, 1);
    expect_out("R9", 0, 0, 0, 3'b010);
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R9", 0, 0, 0, 3'b010);
    apply(0, 0, 0, 0, 0, 0, 0, 1);
    expect_out("R9", 1, 0, 1, 3'b011);
    // level 2 by data lane
    write_cfg(tdr(2'b10, lv(1, 7'b0100000, 0, 0, 0, 0), lv(1, 0, 0, 0, 1, 0)));
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R9", 0, 0, 0, 3'b010);
    apply(1, 2, 1, l2_data_ref, 0, 0, 0, 0);
    expect_out("R9", 0, 1, 1, 3'b011);

    // R10: level 2 disabled, lanes ignored, level 1 completes
    write_cfg(tdr(2'b10, lv(0, 7'h7F, 0, 0, 0, 0), lv(1, 0, 0, 0, 1, 0)));
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R10", 0, 1, 1, 3'b011);

    // R11 / R12: each response code, pulse width, hold after completion
    for (int r = 0; r < 4; r++) begin
      pc1_only = tdr(2'(r), 14'h0, lv(1, 0, 0, 0, 1, 0));
      write_cfg(pc1_only);
      apply(0, 0, 0, 0, 0, 0, 1, 0);
      expect_out("R11", r == 1, r == 2, 1, 3'b011);
      apply(0, 0, 0, 0, 0, 0, 0, 0);
      expect_out("R11", 0, 0, 0, 3'b011);
      apply(0, 0, 0, 0, 0, 0, 1, 1);
      expect_out("R12", 0, 0, 0, 3'b011);
    end

    // R2: write after completion re-arms
    write_cfg(tdr(2'b01, 14'h0, lv(1, 0, 0, 0, 1, 0)));
    expect_out("R2", 0, 0, 0, 3'b001);
    apply(0, 0, 0, 0, 0, 0, 1, 0);
    expect_out("R2", 1, 0, 1, 3'b011);

    // R13: level 1 disabled keeps the unit idle
    write_cfg(tdr(2'b01, lv(1, 0, 0, 0, 1, 0), lv(0, 0, 0, 0, 1, 0)));
    expect_out("R13", 0, 0, 0, 3'b000);
    apply(0, 0, 0, 0, 0, 0, 1, 1);
    expect_out("R13", 0, 0, 0, 3'b000);
    apply(1, 0, 2, l1_data_ref, 1, 1, 1, 1);
    expect_out("R13", 0, 0, 0, 3'b000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule